// File: doc/BRIEF.md
# Reduced-Power Mode Controller

This block sits beside a small 8-bit microcontroller core and sequences its three power states: run, idle and power-down. Software picks a reduced-power state by writing two request bits. In idle the CPU clock and the DMA clock are gated, while the other peripheral clocks keep running. In power-down every on-chip clock stops, and RAM and register contents are left as they were. The block never writes or resets that storage.

All sequencing runs on an internal tick. A divide-by-two flip-flop derives this tick from the input clock, so the duty cycle of the input clock does not matter. The state machine has three states: `PM_RUN`, `PM_IDLE` and `PM_PDOWN`. It changes state only on a tick cycle. The transitions are as follows:
- **RUN to PDOWN:** a write with the power-down bit set. This takes priority over the idle bit.
- **RUN to IDLE:** a write with only the idle bit set.
- **IDLE to RUN:** any interrupt request whose enable is set, sampled on a tick. This clears the idle flag.
- **Hardware reset:** the only way out of PDOWN, and it returns the block to RUN from any state.

While the core is not in run, the block takes over the external bus strobes and the port drive controls. The values it forces depend on the mode and on whether program memory is internal or external.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While and after reset `rst_n`=0, mode_o is 0 (run, encoding 0=run 1=idle 2=power-down), all three clock enables are 1, `bus_ovr` is 0 and `core_tick` is 0.
- R2: Outside power-down, `core_tick` toggles on every `clk_in` cycle, so it is high on exactly half the cycles. The state changes only at an edge where `core_tick` is 1.
- R3: In run, a write (`ctl_wr`=1 held across a tick) with `wr_pdown`=1 enters power-down (mode 2), whatever the value of `wr_idle`.
- R4: In run, a write with `wr_idle`=1 and `wr_pdown`=0 enters idle (mode 1). In idle, `cpu_clk_en` and `dma_clk_en` are 0, `periph_clk_en` is 1, and `idle_flag` is 1.
- R5: In power-down, all three clock enables are 0 and `core_tick` is held at 0.
- R6: In idle, a tick with any bit of `irq_req & irq_en` set returns the block to run, with `idle_flag` at 0. Requests whose enable is 0 leave the block in idle.
- R7: Power-down ignores interrupt requests and control writes. Only `rst_n`=0 leaves it.
- R8: A control write made while in idle has no effect on the mode.
- R9: `bus_ovr` is 1 exactly when the mode is not run. `ale_o` and `pse_o` are 1 in idle and 0 otherwise.
- R10: `adlo_hiz` (the low address/data port released) is 1 when the mode is not run and `ext_prog`=1. Otherwise it is 0, and the port keeps its latched data.
- R11: `adhi_addr` (the high port drives the address rather than latched data) is 1 only in idle with `ext_prog`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock before the divide-by-two |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| ctl_wr | input | 1 | Control-register write strobe |
| wr_idle | input | 1 | Idle request bit of the write |
| wr_pdown | input | 1 | Power-down request bit of the write |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Interrupt enable bits |
| ext_prog | input | 1 | 1 = program memory is external |
| core_tick | output | 1 | Internal clock-edge enable from the divider |
| cpu_clk_en | output | 1 | CPU clock enable |
| dma_clk_en | output | 1 | DMA clock enable |
| periph_clk_en | output | 1 | Enable for the remaining peripheral clocks |
| mode_o | output | 2 | Current mode code |
| idle_flag | output | 1 | Idle request bit as held by hardware |
| pdown_flag | output | 1 | Power-down request bit as held by hardware |
| bus_ovr | output | 1 | External bus pins are forced by this block |
| ale_o | output | 1 | Forced address-latch strobe level |
| pse_o | output | 1 | Forced program-store strobe level |
| adlo_hiz | output | 1 | Low address/data port tristated |
| adhi_addr | output | 1 | High port drives address, not latched data |

## Verification
The hardest situations to reach from the ports are those where two stimuli coincide on the single internal edge that matters. Examples are an enabled interrupt arriving while idle, or a write made while the state machine already sits in power-down. The bench resets the block before every scenario. It holds each write and each interrupt pattern across two input clocks, so exactly one tick edge sees it. It then sweeps all four write-bit pairs, every request and enable pattern of a two-line configuration, and both program-memory settings. After that it tries writes in idle and in power-down, and checks the clock enables and forced pins against a small mode model in the bench.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_PDOWN = 2'd2
    } pm_state_e;
endpackage

// File: rtl/pmc_div2.sv
module pmc_div2 (
    input  logic clk_in,
    input  logic rst_n,
    input  logic halt,
    output logic tick
);
    logic tick_q;

    always_ff @(posedge clk_in) begin
        if (!rst_n)     tick_q <= 1'b0;
        else if (halt)  tick_q <= 1'b0;
        else            tick_q <= ~tick_q;
    end

    assign tick = tick_q;

    // R2: the tick alternates while the clock tree runs
    p_tick_alt_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!halt && tick_q) |=> !tick_q);
    // R5: halted divider stays low
    p_tick_held_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
        halt |=> !tick_q);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int NIRQ = 2
) (
    input  logic            clk_in,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            ctl_wr,
    input  logic            wr_idle,
    input  logic            wr_pdown,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_en,
    output pm_state_e       state
);
    pm_state_e state_q, state_d;
    logic      wake;

    assign wake = |(irq_req & irq_en);

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                PM_RUN: begin
                    if (ctl_wr && wr_pdown)     state_d = PM_PDOWN;
                    else if (ctl_wr && wr_idle) state_d = PM_IDLE;
                end
                PM_IDLE:  if (wake) state_d = PM_RUN;
                PM_PDOWN: state_d = PM_PDOWN;
                default:  state_d = PM_RUN;
            endcase
        end
    end

    always_ff @(posedge clk_in) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= state_d;
    end

    assign state = state_q;

    // R7: power-down is left only through reset
    p_pd_sticky_r7: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state_q == PM_PDOWN) |=> (state_q == PM_PDOWN));
    // R6: an enabled request on a tick ends idle
    p_idle_wake_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state_q == PM_IDLE && tick && wake) |=> (state_q == PM_RUN));
    // R2: no state change away from a tick
    p_tick_only_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
        !tick |=> $stable(state_q));
    // R3: power-down wins over idle
    p_pd_prio_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
        (state_q == PM_RUN && tick && ctl_wr && wr_pdown) |=> (state_q == PM_PDOWN));
endmodule

// File: rtl/pmc_pin_ovr.sv
module pmc_pin_ovr
    import pmc_pkg::*;
(
    input  pm_state_e state,
    input  logic      ext_prog,
    output logic      bus_ovr,
    output logic      ale_o,
    output logic      pse_o,
    output logic      adlo_hiz,
    output logic      adhi_addr
);
    always_comb begin
        bus_ovr   = 1'b0;
        ale_o     = 1'b0;
        pse_o     = 1'b0;
        adlo_hiz  = 1'b0;
        adhi_addr = 1'b0;
        unique case (state)
            PM_RUN: ;
            PM_IDLE: begin
                bus_ovr   = 1'b1;
                ale_o     = 1'b1;
                pse_o     = 1'b1;
                adlo_hiz  = ext_prog;
                adhi_addr = ext_prog;
            end
            PM_PDOWN: begin
                bus_ovr   = 1'b1;
                adlo_hiz  = ext_prog;
            end
            default: ;
        endcase
    end

    // R11: address only ever driven during idle
    always_comb begin
        if (adhi_addr) p_hi_addr_idle_r11: assert (state == PM_IDLE && ext_prog);
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NIRQ = 2
) (
    input  logic            clk_in,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic            wr_idle,
    input  logic            wr_pdown,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_en,
    input  logic            ext_prog,
    output logic            core_tick,
    output logic            cpu_clk_en,
    output logic            dma_clk_en,
    output logic            periph_clk_en,
    output logic [1:0]      mode_o,
    output logic            idle_flag,
    output logic            pdown_flag,
    output logic            bus_ovr,
    output logic            ale_o,
    output logic            pse_o,
    output logic            adlo_hiz,
    output logic            adhi_addr
);
    pm_state_e state;
    logic      tick;
    logic      halt;

    assign halt = (state == PM_PDOWN);

    pmc_div2 u_div (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .halt   (halt),
        .tick   (tick)
    );

    pmc_fsm #(.NIRQ(NIRQ)) u_fsm (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctl_wr   (ctl_wr),
        .wr_idle  (wr_idle),
        .wr_pdown (wr_pdown),
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .state    (state)
    );

    pmc_pin_ovr u_pins (
        .state     (state),
        .ext_prog  (ext_prog),
        .bus_ovr   (bus_ovr),
        .ale_o     (ale_o),
        .pse_o     (pse_o),
        .adlo_hiz  (adlo_hiz),
        .adhi_addr (adhi_addr)
    );

    always_comb begin
        cpu_clk_en    = 1'b1;
        dma_clk_en    = 1'b1;
        periph_clk_en = 1'b1;
        idle_flag     = 1'b0;
        pdown_flag    = 1'b0;
        unique case (state)
            PM_RUN: ;
            PM_IDLE: begin
                cpu_clk_en = 1'b0;
                dma_clk_en = 1'b0;
                idle_flag  = 1'b1;
            end
            PM_PDOWN: begin
                cpu_clk_en    = 1'b0;
                dma_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
                pdown_flag    = 1'b1;
            end
            default: ;
        endcase
    end

    assign core_tick = tick;
    assign mode_o    = state;

    // R9: strobes forced high only in idle
    p_strobe_idle_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
        idle_flag |-> (ale_o && pse_o && bus_ovr));
    // R10: low port floats outside run with external program memory
    p_lo_float_r10: assert property (@(posedge clk_in) disable iff (!rst_n)
        (bus_ovr && ext_prog) |-> adlo_hiz);
    // R5: nothing clocked in power-down
    p_pd_clocks_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
        pdown_flag |-> !(cpu_clk_en || dma_clk_en || periph_clk_en || core_tick));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 2;
    localparam int WATCHDOG = 100000;

    logic clk_in = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0, wr_idle = 1'b0, wr_pdown = 1'b0;
    logic [NIRQ-1:0] irq_req = '0, irq_en = '0;
    logic ext_prog = 1'b0;
    logic core_tick, cpu_clk_en, dma_clk_en, periph_clk_en;
    logic [1:0] mode_o;
    logic idle_flag, pdown_flag, bus_ovr, ale_o, pse_o, adlo_hiz, adhi_addr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk_in = ~clk_in;

    pwr_mode_ctrl #(.NIRQ(NIRQ)) dut_i (
        .clk_in(clk_in), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_idle(wr_idle),
        .wr_pdown(wr_pdown), .irq_req(irq_req), .irq_en(irq_en), .ext_prog(ext_prog),
        .core_tick(core_tick), .cpu_clk_en(cpu_clk_en), .dma_clk_en(dma_clk_en),
        .periph_clk_en(periph_clk_en), .mode_o(mode_o), .idle_flag(idle_flag),
        .pdown_flag(pdown_flag), .bus_ovr(bus_ovr), .ale_o(ale_o), .pse_o(pse_o),
        .adlo_hiz(adlo_hiz), .adhi_addr(adhi_addr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // mode model: 0 run, 1 idle, 2 power-down
    task automatic check_outputs(input int m, input string tag);
        check({tag, " R4/R5 mode"}, mode_o, m);
        check({tag, " R4 cpu_en"}, cpu_clk_en, m == 0);
        check({tag, " R4 dma_en"}, dma_clk_en, m == 0);
        check({tag, " R5 periph_en"}, periph_clk_en, m != 2);
        check({tag, " R6 idle_flag"}, idle_flag, m == 1);
        check({tag, " R9 bus_ovr"}, bus_ovr, m != 0);
        check({tag, " R9 ale"}, ale_o, m == 1);
        check({tag, " R9 pse"}, pse_o, m == 1);
        check({tag, " R10 lo_hiz"}, adlo_hiz, (m != 0) && ext_prog);
        check({tag, " R11 hi_addr"}, adhi_addr, (m == 1) && ext_prog);
    endtask

    task automatic do_reset();
        @(negedge clk_in);
        rst_n = 1'b0;
        ctl_wr = 0; wr_idle = 0; wr_pdown = 0; irq_req = '0; irq_en = '0;
        @(negedge clk_in);
        @(negedge clk_in);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic i, input logic p);
        ctl_wr = 1; wr_idle = i; wr_pdown = p;
        @(negedge clk_in);
        @(negedge clk_in);
        ctl_wr = 0; wr_idle = 0; wr_pdown = 0;
    endtask

    task automatic do_irq(input logic [NIRQ-1:0] r, input logic [NIRQ-1:0] e);
        irq_req = r; irq_en = e;
        @(negedge clk_in);
        @(negedge clk_in);
        irq_req = '0; irq_en = '0;
    endtask

    initial begin
        while (cyc < WATCHDOG) begin
            @(posedge clk_in);
            cyc++;
        end
        n_fail++;
        $display("FAIL watchdog: actual %0d expected < %0d", cyc, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int m;
        int highs;
        do_reset();
        // R1: reset state
        rst_n = 1'b0;
        @(negedge clk_in);
        check("R1 mode", mode_o, 0);
        check("R1 tick", core_tick, 0);
        check("R1 bus_ovr", bus_ovr, 0);
        check("R1 clocks", {cpu_clk_en, dma_clk_en, periph_clk_en}, 3'b111);
        rst_n = 1'b1;

        // R2: divider duty in run
        highs = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk_in);
            highs += core_tick;
        end
        check("R2 tick count", highs, 10);

        // R3 R4 R6 R9 R10 R11 sweep
        for (int ep = 0; ep < 2; ep++) begin
            for (int w = 0; w < 4; w++) begin
                for (int pat = 0; pat < 16; pat++) begin
                    ext_prog = ep[0];
                    do_reset();
                    @(negedge clk_in);
                    do_write(w[0], w[1]);
                    m = w[1] ? 2 : (w[0] ? 1 : 0);
                    check_outputs(m, "R3 write");
                    do_irq(pat[1:0], pat[3:2]);
                    if (m == 1 && ((pat[1:0] & pat[3:2]) != 0)) m = 0;
                    check_outputs(m, "R6/R7 irq");
                end
            end
        end

        // R2 R5: tick held in power-down
        do_reset();
        @(negedge clk_in);
        do_write(0, 1);
        highs = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk_in);
            highs += core_tick;
        end
        check("R5 tick in pdown", highs, 0);

        // R7: writes ignored in power-down
        do_write(1, 0);
        check("R7 write in pdown", mode_o, 2);
        do_reset();
        @(negedge clk_in);
        check("R7 reset exits pdown", mode_o, 0);

        // R8: writes ignored in idle; R2 tick keeps running in idle
        do_write(1, 0);
        check("R8 enter idle", mode_o, 1);
        do_write(0, 1);
        check("R8 pdown write in idle", mode_o, 1);
        do_write(1, 1);
        check("R8 both write in idle", mode_o, 1);
        highs = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk_in);
            highs += core_tick;
        end
        check("R2 tick in idle", highs, 5);
        do_irq(2'b10, 2'b10);
        check("R6 wake", mode_o, 0);
        check("R6 flag cleared", idle_flag, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule